// File: doc/BRIEF.md
# Four-Mode Bidirectional Shift Register

This block is a small universal shift register with a parallel data path and two serial paths. On each rising clock edge a two-bit mode input selects one of four actions: capture a parallel word, move the contents one place toward the most significant bit, move them one place toward the least significant bit, or keep them as they are. Bit 0 is the first stage. A right shift feeds a serial bit in at bit 0, and a left shift feeds one in at the top bit. Several copies can be chained by wiring the end bits of one to the serial inputs of the next.

An active-low clear forces the contents to zero at once, without waiting for the clock, and holds them there for as long as it stays low. Its release passes through a two-stage synchronizer, so the register stays idle for the first two rising edges after release. The mode lines may change only while the clock is high. A sticky flag output reports any mode change made while the clock was low, and only a clear resets that flag.

Top module: `uni_shift_reg`

## Requirements
- R1: With mode = 2'b11 (load), the register takes par_d on the rising edge, and ser_r and ser_l have no effect.
- R2: With mode = 2'b01 (shift right), on the rising edge q[i] takes q[i-1] for i >= 1 and q[0] takes ser_r.
- R3: With mode = 2'b10 (shift left), on the rising edge q[i] takes q[i+1] for i < WIDTH-1 and q[WIDTH-1] takes ser_l.
- R4: With mode = 2'b00 (hold), the contents do not change on the rising edge, whatever the data and serial inputs are.
- R5: While clr_n is low, q and mode_viol are zero, starting at once without a clock edge, and rising edges have no effect.
- R6: After clr_n rises, the first two rising edges leave q at zero, and the third rising edge applies the selected mode.
- R7: Outside clear, mode_viol goes high on a rising edge when mode differs from its value at the preceding falling edge. A mode change made while the clock is high does not set it.
- R8: Once set, mode_viol stays high through any mode and data activity until clr_n goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| clr_n | input | 1 | Active-low clear; asserts asynchronously, released through a synchronizer |
| mode | input | 2 | Operation select: 00 hold, 01 shift right, 10 shift left, 11 load |
| par_d | input | WIDTH | Parallel load word |
| ser_r | input | 1 | Serial bit that enters at bit 0 on a right shift |
| ser_l | input | 1 | Serial bit that enters at bit WIDTH-1 on a left shift |
| q | output | WIDTH | Register contents |
| mode_viol | output | 1 | Sticky flag for a mode change made while the clock was low |

## Verification
The assertions in the register and flag logic check, on every active edge, that load, both shift directions and hold give the expected next contents, and that the violation flag never drops outside clear. The asynchronous effect of clear, the two idle edges after its release, and whether the flag is set or stays clear depend on when the inputs change within the clock period. Only the bench's timed scenarios can show these: clear asserted in the middle of a shift sequence, mode changes made in the low and in the high clock phase, and a clear of a set flag.

// File: rtl/ushift_pkg.sv
package ushift_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    M_HOLD = 2'b00,
    M_SHR  = 2'b01,
    M_SHL  = 2'b10,
    M_LOAD = 2'b11
  } mode_e;
endpackage

// File: rtl/ushift_rst_release.sv
// Asynchronous assert, synchronous release of the active-low clear.
module ushift_rst_release #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ushift_core.sv
// Register stages with mode-driven next-state selection.
module ushift_core
  import ushift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic [WIDTH-1:0]  par_d,
  input  logic              ser_r,
  input  logic              ser_l,
  output logic [WIDTH-1:0]  q
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_nxt;
  logic [WIDTH-1:0] shr_v;
  logic [WIDTH-1:0] shl_v;
  logic             q_en;

  // Per-stage neighbour selection for both shift directions.
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign shr_v[i] = ser_r;
    end else begin : g_rest_r
      assign shr_v[i] = q_r[i-1];
    end
    if (i == MSB) begin : g_last
      assign shl_v[i] = ser_l;
    end else begin : g_rest_l
      assign shl_v[i] = q_r[i+1];
    end
  end

  always_comb begin
    q_nxt = q_r;
    q_en  = 1'b0;
    case (mode_e'(mode))
      M_LOAD:  begin q_nxt = par_d; q_en = 1'b1; end
      M_SHR:   begin q_nxt = shr_v; q_en = 1'b1; end
      M_SHL:   begin q_nxt = shl_v; q_en = 1'b1; end
      default: begin q_nxt = q_r;   q_en = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_en) q_r <= q_nxt;
  end

  assign q = q_r;

  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && mode == M_LOAD) |=> (q == $past(par_d)));

  a_r2_shift_right: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && mode == M_SHR) |=> (q == {$past(q[MSB-1:0]), $past(ser_r)}));

  a_r3_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && mode == M_SHL) |=> (q == {$past(ser_l), $past(q[MSB:1])}));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && mode == M_HOLD) |=> $stable(q));
endmodule

// File: rtl/ushift_mode_watch.sv
// Flags a mode change made while the clock was low.
module ushift_mode_watch
  import ushift_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  output logic              viol
);
  logic [MODE_W-1:0] mode_fall_q;
  logic              flag_q;
  logic              flag_nxt;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) mode_fall_q <= '0;
    else        mode_fall_q <= mode;
  end

  always_comb begin
    flag_nxt = flag_q | (mode != mode_fall_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_nxt;
  end

  assign viol = flag_q;

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q);
endmodule

// File: rtl/uni_shift_reg.sv
module uni_shift_reg
  import ushift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic [MODE_W-1:0] mode,
  input  logic [WIDTH-1:0]  par_d,
  input  logic              ser_r,
  input  logic              ser_l,
  output logic [WIDTH-1:0]  q,
  output logic              mode_viol
);
  logic rst_n;

  ushift_rst_release #(.STAGES(2)) u_rel (
    .clk   (clk),
    .clr_n (clr_n),
    .rst_n (rst_n)
  );

  ushift_core #(.WIDTH(WIDTH)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode),
    .par_d (par_d),
    .ser_r (ser_r),
    .ser_l (ser_l),
    .q     (q)
  );

  ushift_mode_watch u_watch (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode),
    .viol  (mode_viol)
  );
endmodule

// File: tb/uni_shift_reg_tb_top.sv
module uni_shift_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  typedef struct {
    logic [W-1:0] q;
    logic         f;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         clr_n;
  logic [1:0]   mode;
  logic [W-1:0] par_d;
  logic         ser_r;
  logic         ser_l;
  logic [W-1:0] q;
  logic         mode_viol;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  exp_t         sbq[$];
  logic [W-1:0] mdl = '0;
  logic         flg = 1'b0;
  int           since = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uni_shift_reg #(.WIDTH(W)) dut_i (
    .clk       (clk),
    .clr_n     (clr_n),
    .mode      (mode),
    .par_d     (par_d),
    .ser_r     (ser_r),
    .ser_l     (ser_l),
    .q         (q),
    .mode_viol (mode_viol)
  );

  // Reference model for the next rising edge, then push the expectation.
  task automatic model(input logic [1:0] m, input logic [W-1:0] d,
                       input logic sr, input logic sl, input logic c,
                       input logic low_chg, input string tag);
    exp_t e;
    if (!c) begin
      mdl = '0; flg = 1'b0; since = 0;
    end else begin
      since++;
      if (since >= 3) begin
        case (m)
          2'b11: mdl = d;
          2'b01: mdl = {mdl[W-2:0], sr};
          2'b10: mdl = {sl, mdl[W-1:1]};
          default: mdl = mdl;
        endcase
        if (low_chg) flg = 1'b1;
      end
    end
    e.q = mdl; e.f = flg; e.tag = tag;
    sbq.push_back(e);
  endtask

  // Normal step: all inputs change while the clock is high.
  task automatic step(input logic [1:0] m, input logic [W-1:0] d,
                      input logic sr, input logic sl, input logic c,
                      input string tag);
    @(posedge clk); #2;
    mode = m; par_d = d; ser_r = sr; ser_l = sl; clr_n = c;
    model(m, d, sr, sl, c, 1'b0, tag);
  endtask

  // Mode change made during the low clock phase.
  task automatic late_mode(input logic [1:0] m, input logic [W-1:0] d,
                           input logic sr, input logic sl, input string tag);
    logic chg;
    @(posedge clk); #2;
    par_d = d; ser_r = sr; ser_l = sl;
    @(negedge clk); #2;
    chg  = (m != mode);
    mode = m;
    model(m, d, sr, sl, 1'b1, chg, tag);
  endtask

  task automatic check_now(input logic [W-1:0] eq, input logic ef, input string tag);
    total++;
    if (q !== eq || mode_viol !== ef) begin
      bad++;
      $display("FAIL %s q=%h exp=%h flag=%b exp=%b", tag, q, eq, mode_viol, ef);
    end
  endtask

  // Monitor: compare after every rising edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        total++;
        if (q !== e.q || mode_viol !== e.f) begin
          bad++;
          $display("FAIL %s q=%h exp=%h flag=%b exp=%b", e.tag, q, e.q, mode_viol, e.f);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clr_n = 1'b0; mode = 2'b00; par_d = '0; ser_r = 1'b0; ser_l = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    check_now('0, 1'b0, "R5 reset state");
    step(2'b11, 4'hA, 1, 1, 0, "R5 edge ignored in clear");
    step(2'b11, 4'h5, 0, 0, 1, "R6 idle edge 1");
    step(2'b11, 4'h5, 0, 0, 1, "R6 idle edge 2");
    step(2'b11, 4'hA, 1, 1, 1, "R1 load A");
    step(2'b11, 4'h3, 0, 1, 1, "R1 load serial ignored");
    step(2'b01, 4'hF, 1, 0, 1, "R2 shift right in 1");
    step(2'b01, 4'hF, 0, 1, 1, "R2 shift right in 0");
    step(2'b01, 4'h0, 1, 1, 1, "R2 shift right in 1");
    step(2'b00, 4'hF, 1, 1, 1, "R4 hold");
    step(2'b00, 4'h0, 0, 0, 1, "R4 hold again");
    step(2'b10, 4'hF, 1, 0, 1, "R3 shift left in 0");
    step(2'b10, 4'h0, 0, 1, 1, "R3 shift left in 1");
    step(2'b10, 4'h0, 0, 1, 1, "R3 shift left in 1");
    step(2'b01, 4'h0, 1, 0, 1, "R2 shift right mid-run");
    step(2'b01, 4'h0, 1, 0, 0, "R5 clear mid-sequence");
    #2;
    check_now('0, 1'b0, "R5 clear is immediate");
    step(2'b10, 4'h0, 0, 1, 0, "R5 shift ignored in clear");
    step(2'b11, 4'h9, 0, 0, 1, "R6 idle edge 1");
    step(2'b11, 4'h9, 0, 0, 1, "R6 idle edge 2");
    step(2'b11, 4'h9, 0, 0, 1, "R6 third edge loads");
    late_mode(2'b11, 4'h6, 1, 1, "R7 same mode in low phase");
    late_mode(2'b01, 4'h0, 0, 0, "R7 mode change in low phase");
    step(2'b01, 4'h0, 1, 0, 1, "R8 flag stays");
    step(2'b00, 4'h0, 0, 0, 1, "R8 flag stays on hold");
    step(2'b00, 4'h0, 0, 0, 0, "R8 clear drops flag");
    step(2'b11, 4'hC, 0, 0, 1, "R6 idle edge 1");
    step(2'b11, 4'hC, 0, 0, 1, "R6 idle edge 2");
    step(2'b11, 4'hC, 0, 0, 1, "R7 high-phase change leaves flag low");
    repeat (2) @(posedge clk);
    #3;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule